// File: doc/BRIEF.md
# Key Pulse Frequency Window Checker

This block watches a toggling security-key line and decides whether the line's frequency falls inside a programmable acceptance window. A free-running counter advances on a low-rate sample tick derived from the system clock. Each rising edge of the synchronized key line stores the counter value in a capture register. A separate check timer fires at a fixed interval. At each check the block compares the newest captured value with the value kept from the previous check. The difference, taken modulo the counter width, is the key period in sample ticks.

A period between the two threshold inputs, bounds included, raises the enable flag. A period outside them drops it. A check that sees no new capture leaves the flag as it is. The first check after reset only stores the capture value. The flag appears on its own pin and also in a status byte for a neighbouring link.

All pins are plain control and status signals. No data stream passes through the block, so it has no valid/ready handshake and no back-pressure. With the defaults, a 12.5829 MHz clock divided by 192 gives a sample tick near 65,536 Hz, and the check fires every 12.5 ms. Under those settings a 50 Hz key gives a count near 1310, and bounds of 1192 and 1456 accept roughly 45 to 55 Hz.

Top module: `key_window_chk`

## Requirements
- R1: While `rst_n` is low and after it is released, `fuel_en_o` is 0 and `status_o` is 8'h00 until a check accepts a period.
- R2: The capture counter advances once every `SMP_DIV` system clock cycles, so a key period of P·`SMP_DIV` clocks measures as exactly P counts.
- R3: Only a rising edge of the key input, after a two-flop synchronizer, updates the capture register.
- R4: A decision is taken only at a check, which occurs once every `CHK_CYC` system clock cycles. The outputs reflect it within one check interval plus four clocks of the rising edge.
- R5: The first check after reset stores the capture value and does not change `fuel_en_o`.
- R6: A check whose capture value equals the stored value takes no action, and `fuel_en_o` holds.
- R7: A measured period p with `thr_lo_i` ≤ p ≤ `thr_hi_i` sets `fuel_en_o` to 1. Both bounds are inclusive.
- R8: A measured period below `thr_lo_i` or above `thr_hi_i` clears `fuel_en_o` to 0.
- R9: The period is the capture difference modulo 2^`CNT_W`, so it is measured correctly across a counter wrap.
- R10: `status_o` bit 2 equals `fuel_en_o`, and all other status bits are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_i | input | 1 | Asynchronous toggling key line |
| thr_lo_i | input | CNT_W | Smallest accepted period in sample ticks (highest frequency) |
| thr_hi_i | input | CNT_W | Largest accepted period in sample ticks (lowest frequency) |
| fuel_en_o | output | 1 | Frequency-in-window enable flag |
| status_o | output | 8 | Status byte; bit 2 carries the enable flag |

## Verification
A key rising edge reaches the capture register three clocks after it appears on the pin. The next check pulse then updates the flag one clock after it fires, so a verdict can take up to one check interval plus four clocks to appear. The bench therefore samples each verdict more than one full check interval after the last rising edge of a pattern. It holds the key quiet during that wait, so no later edge can change the result. Key periods are kept longer than the check interval, so each check sees at most one new edge, and exact multiples of the sample divider make every measured period an exact count. The tests include the two bounds, one count beyond each bound, and long idle stretches after both an accepted and a rejected period.

// File: rtl/kpw_pkg.sv
package kpw_pkg;
  localparam int STAT_W      = 8;
  localparam int STAT_EN_BIT = 2;
endpackage

// File: rtl/kpw_pulse_div.sv
module kpw_pulse_div #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic pulse_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  generate
    if (DIV > 1) begin : g_div
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q   <= '0;
          pulse_o <= 1'b0;
        end else begin
          pulse_o <= (cnt_q == CW'(DIV - 1));
          if (cnt_q == CW'(DIV - 1)) cnt_q <= '0;
          else                       cnt_q <= cnt_q + 1'b1;
        end
      end
      AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |=> !pulse_o); // R2
    end else begin : g_pass
      assign pulse_o = rst_n;
    end
  endgenerate
endmodule

// File: rtl/kpw_edge_capture.sv
module kpw_edge_capture #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cap_o
);
  logic s1_q, s2_q, s3_q, rise;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= key_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rise = s2_q & ~s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cap_o <= '0;
    else if (rise) cap_o <= cnt_q;
  end

  AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rise |=> $stable(cap_o)); // R3
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(cnt_q)); // R2
endmodule

// File: rtl/kpw_judge.sv
module kpw_judge #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chk_i,
  input  logic [CNT_W-1:0] cap_i,
  input  logic [CNT_W-1:0] lo_i,
  input  logic [CNT_W-1:0] hi_i,
  output logic             en_o
);
  logic             primed_q;
  logic [CNT_W-1:0] prev_q;
  logic [CNT_W-1:0] diff;
  logic             fresh, in_win;

  assign diff   = cap_i - prev_q;
  assign fresh  = (cap_i != prev_q);
  assign in_win = (diff >= lo_i) && (diff <= hi_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed_q <= 1'b0;
      prev_q   <= '0;
      en_o     <= 1'b0;
    end else if (chk_i) begin
      if (!primed_q) begin
        primed_q <= 1'b1;
        prev_q   <= cap_i;
      end else if (fresh) begin
        prev_q <= cap_i;
        en_o   <= in_win;
      end
    end
  end

  AST_EN_ONLY_AT_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_i |=> $stable(en_o)); // R4
  AST_FIRST_RECORD: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_i && !primed_q) |=> (!en_o && $stable(en_o))); // R5
  AST_NO_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_i && primed_q && cap_i == prev_q) |=> $stable(en_o)); // R6
  AST_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_i && primed_q && fresh && (CNT_W'(cap_i - prev_q) >= lo_i)
     && (CNT_W'(cap_i - prev_q) <= hi_i)) |=> en_o); // R7
  AST_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_i && primed_q && fresh && ((CNT_W'(cap_i - prev_q) < lo_i)
     || (CNT_W'(cap_i - prev_q) > hi_i))) |=> !en_o); // R8
endmodule

// File: rtl/key_window_chk.sv
module key_window_chk #(
  parameter int SMP_DIV = 192,
  parameter int CHK_CYC = 157286,
  parameter int CNT_W   = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       key_i,
  input  logic [CNT_W-1:0]           thr_lo_i,
  input  logic [CNT_W-1:0]           thr_hi_i,
  output logic                       fuel_en_o,
  output logic [kpw_pkg::STAT_W-1:0] status_o
);
  import kpw_pkg::*;

  logic             smp_tick, chk_tick;
  logic [CNT_W-1:0] cap;

  kpw_pulse_div #(.DIV(SMP_DIV)) u_smp (
    .clk(clk), .rst_n(rst_n), .pulse_o(smp_tick));

  kpw_pulse_div #(.DIV(CHK_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .pulse_o(chk_tick));

  kpw_edge_capture #(.CNT_W(CNT_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .key_i(key_i), .tick_i(smp_tick), .cap_o(cap));

  kpw_judge #(.CNT_W(CNT_W)) u_judge (
    .clk(clk), .rst_n(rst_n), .chk_i(chk_tick), .cap_i(cap),
    .lo_i(thr_lo_i), .hi_i(thr_hi_i), .en_o(fuel_en_o));

  always_comb begin
    status_o              = '0;
    status_o[STAT_EN_BIT] = fuel_en_o;
  end

  AST_STATUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(status_o) == (fuel_en_o ? 1 : 0)); // R10
endmodule

// File: tb/sim_key_window_chk.sv
module sim_key_window_chk;
  localparam int SMP = 4;
  localparam int CHK = 400;
  localparam int CW  = 8;
  localparam int NV  = 6;
  // key period in sample ticks, expected flag
  localparam int PER [NV] = '{150, 119, 120, 180, 181, 130};
  localparam int EXP [NV] = '{1,   0,   1,   1,   0,   1};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          key = 1'b0;
  logic [CW-1:0] lo = 8'd120;
  logic [CW-1:0] hi = 8'd180;
  logic          en;
  logic [7:0]    st;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  key_window_chk #(.SMP_DIV(SMP), .CHK_CYC(CHK), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .key_i(key), .thr_lo_i(lo), .thr_hi_i(hi),
    .fuel_en_o(en), .status_o(st));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_key(input int ticks, input int reps);
    for (int r = 0; r < reps; r++) begin
      key = 1'b1; idle(ticks * SMP / 2);
      key = 1'b0; idle(ticks * SMP - ticks * SMP / 2);
    end
  endtask

  initial begin
    idle(5);
    chk("R1 en in reset", en, 0);
    chk("R10 status in reset", st, 0);
    rst_n = 1'b1;
    idle(3);
    chk("R1 en after reset", en, 0);
    // R5: an edge before the first check would measure ~25 ticks against 0
    lo = 8'd10; hi = 8'd40;
    idle(97);
    key = 1'b1; idle(20); key = 1'b0;
    idle(600);
    chk("R5 first check only records", en, 0);
    lo = 8'd120; hi = 8'd180;
    // table: R2 R4 R7 R8 R9 (8-bit counter wraps within every pattern)
    for (int i = 0; i < NV; i++) begin
      run_key(PER[i], 5);
      idle(CHK + 20);
      chk($sformatf("R7/R8 period %0d", PER[i]), en, EXP[i]);
      chk($sformatf("R10 status period %0d", PER[i]), st, EXP[i] << 2);
    end
    idle(3 * CHK);
    chk("R6 hold accepted with no edges", en, 1);
    run_key(181, 5);
    idle(CHK + 20);
    chk("R8 above window", en, 0);
    idle(3 * CHK);
    chk("R6 hold rejected with no edges", en, 0);
    run_key(150, 5);
    idle(CHK + 20);
    chk("R4 verdict within one interval", en, 1);
    rst_n = 1'b0;
    idle(2);
    chk("R1 reset clears flag", en, 0);
    chk("R1 reset clears status", st, 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule